// File: doc/BRIEF.md
# Two-Way Page Translation Buffer

This block keeps recently used virtual-to-physical page translations in a two-way set-associative array so that a lookup usually completes without a page-table access. A requester presents a virtual page number together with a read or write flag. In the same cycle the block reports one of three outcomes: a hit with the physical page number, a miss, or a protection fault. A protection fault means a translation exists but its permission bits forbid the access. After a miss, an external page-table walker supplies the translation through a refill port. The retried lookup in a later cycle then hits.

Each entry stores a valid flag, a dirty flag, a referenced flag, two permission bits, the tag and the physical page number. A permitted lookup updates the entry's status flags at the next clock edge. Each set keeps one recency bit, and the refill path uses it to pick the way to overwrite. A flush input discards every translation at once, for example when the address space changes. There is no state machine, because every operation completes in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The low SET_W bits of a virtual page number (8 by default) select the set, and the remaining upper bits form the tag. After reset every lookup misses. A lookup whose tag matches but whose set bits differ also misses.
- R2: Once a present refill has been written at a clock edge, a lookup of the same page in any later cycle finds the entry. If the access is permitted, the lookup returns the refilled physical page number in the same cycle it is presented.
- R3: Permission bit 0 grants reads and bit 1 grants writes. A lookup that matches an entry lacking the needed bit raises `lk_fault`, does not raise `lk_hit`, and drives `lk_ppn` to zero.
- R4: A permitted lookup sets the entry's referenced flag. `lk_ref` shows the flag's value before the current lookup updates it.
- R5: A permitted write sets the entry's dirty flag. A faulting write leaves the dirty flag unchanged. `lk_dirty` shows the current flag on both a hit and a fault.
- R6: Two different pages that share a set can be present at the same time, and each returns its own physical page number.
- R7: A refill writes an invalid way of the set if one exists, otherwise the least recently used way. A permitted lookup or a refill makes the accessed way the most recently used.
- R8: A refill of a page that is already present overwrites that same way, so one page never occupies two ways.
- R9: A refill with `rf_present` low changes nothing.
- R10: `flush_all` invalidates every entry at the clock edge, and a refill presented in the same cycle is discarded. A lookup presented in the flush cycle still sees the entries as they were before the flush.
- R11: At most one of `lk_hit`, `lk_miss` and `lk_fault` is high, and all three are low while `lk_valid` is low.
- R12: A refilled entry starts with its dirty and referenced flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate all entries at the clock edge |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write (1) or a read (0) |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No translation present |
| lk_fault | output | 1 | Translation found but permission missing |
| lk_ppn | output | PPN_W | Physical page number on a hit, otherwise zero |
| lk_dirty | output | 1 | Matched entry's dirty flag (hit or fault) |
| lk_ref | output | 1 | Matched entry's referenced flag before this lookup (hit or fault) |
| rf_valid | input | 1 | Refill request this cycle |
| rf_present | input | 1 | Page is resident, so the refill may be written |
| rf_vpn | input | VPN_W | Virtual page number of the refill |
| rf_ppn | input | PPN_W | Physical page number of the refill |
| rf_rights | input | 2 | Permission bits of the refill (bit 0 read, bit 1 write) |

## Verification
The assertions assume that the inputs are known values after reset. They also assume that a lookup and a refill of the same set are not presented in the same cycle. If both arrive together, the refill's recency update overrides the lookup's, and the retry and sticky-dirty properties reason about one operation at a time. The directed stimulus keeps to these assumptions. It issues one operation per cycle and returns all request lines to idle between operations. The only exception is the flush scenario, which deliberately combines a flush, a refill and a lookup in one cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int DEF_VPN_W = 26;
    localparam int DEF_PPN_W = 22;
    localparam int DEF_SET_W = 8;
    localparam int NUM_WAYS  = 2;
    localparam int PERM_W    = 2;
    // permission bit positions
    localparam int PERM_RD   = 0;
    localparam int PERM_WR   = 1;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
    parameter int SET_W = 8,
    parameter int TAG_W = 18,
    parameter int PPN_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SET_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PPN_W-1:0] rd_ppn,
    output logic [1:0]       rd_perm,
    output logic             rd_dirty,
    output logic             rd_ref,
    input  logic [SET_W-1:0] pr_idx,
    output logic             pr_valid,
    output logic [TAG_W-1:0] pr_tag,
    input  logic             touch_en,
    input  logic             touch_dirty,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_perm
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]  vld_q, drt_q, ref_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [PPN_W-1:0] ppn_q  [SETS];
    logic [1:0]       perm_q [SETS];

    // status flags: reset, flush, touch then fill (fill wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            drt_q <= '0;
            ref_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else begin
            if (touch_en) begin
                ref_q[rd_idx] <= 1'b1;
                if (touch_dirty) drt_q[rd_idx] <= 1'b1;
            end
            if (fill_en) begin
                vld_q[fill_idx] <= 1'b1;
                drt_q[fill_idx] <= 1'b0;
                ref_q[fill_idx] <= 1'b0;
            end
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            ppn_q[fill_idx]  <= fill_ppn;
            perm_q[fill_idx] <= fill_perm;
        end
    end

    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_ppn   = ppn_q[rd_idx];
        rd_perm  = perm_q[rd_idx];
        rd_dirty = drt_q[rd_idx];
        rd_ref   = ref_q[rd_idx];
        pr_valid = vld_q[pr_idx];
        pr_tag   = tag_q[pr_idx];
    end
endmodule

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
    parameter int TAG_W = 18,
    parameter int WAYS  = 2
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            match,
    output logic                       any,
    output logic                       way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == key);
    end
    assign any = |match;
    assign way = match[1];
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim (
    input  logic [1:0] match,
    input  logic [1:0] valid,
    input  logic       lru_way,
    output logic       pick
);
    always_comb begin
        if (|match)         pick = match[1];
        else if (!valid[0]) pick = 1'b0;
        else if (!valid[1]) pick = 1'b1;
        else                pick = lru_way;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VPN_W = DEF_VPN_W,
    parameter int PPN_W = DEF_PPN_W,
    parameter int SET_W = DEF_SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_dirty,
    output logic             lk_ref,
    input  logic             rf_valid,
    input  logic             rf_present,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic [1:0]       rf_rights
);
    localparam int TAG_W = VPN_W - SET_W;
    localparam int SETS  = 1 << SET_W;

    logic [SET_W-1:0] lk_idx, rf_idx;
    logic [TAG_W-1:0] lk_tag, rf_tag;
    assign lk_idx = lk_vpn[SET_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_W];
    assign rf_idx = rf_vpn[SET_W-1:0];
    assign rf_tag = rf_vpn[VPN_W-1:SET_W];

    logic [NUM_WAYS-1:0]            w_vld, w_dirty, w_ref, p_vld, touch, fill;
    logic [NUM_WAYS-1:0][TAG_W-1:0] w_tag, p_tag;
    logic [NUM_WAYS-1:0][PPN_W-1:0] w_ppn;
    logic [NUM_WAYS-1:0][1:0]       w_perm;
    logic [NUM_WAYS-1:0]            lk_match, rf_match;
    logic                           found, hit_way, rf_any, rf_way, victim;
    logic                           allowed, fill_go;
    logic [SETS-1:0]                lru_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
            .clk(clk), .rst_n(rst_n), .flush(flush_all),
            .rd_idx(lk_idx), .rd_valid(w_vld[w]), .rd_tag(w_tag[w]),
            .rd_ppn(w_ppn[w]), .rd_perm(w_perm[w]), .rd_dirty(w_dirty[w]),
            .rd_ref(w_ref[w]),
            .pr_idx(rf_idx), .pr_valid(p_vld[w]), .pr_tag(p_tag[w]),
            .touch_en(touch[w]), .touch_dirty(lk_write),
            .fill_en(fill[w]), .fill_idx(rf_idx), .fill_tag(rf_tag),
            .fill_ppn(rf_ppn), .fill_perm(rf_rights)
        );
        assign touch[w] = lk_hit && (hit_way == w[0]);
        assign fill[w]  = fill_go && (victim == w[0]);
    end

    tlb_tag_cmp #(.TAG_W(TAG_W), .WAYS(NUM_WAYS)) u_lk_cmp (
        .valid(w_vld), .tags(w_tag), .key(lk_tag),
        .match(lk_match), .any(found), .way(hit_way)
    );

    tlb_tag_cmp #(.TAG_W(TAG_W), .WAYS(NUM_WAYS)) u_rf_cmp (
        .valid(p_vld), .tags(p_tag), .key(rf_tag),
        .match(rf_match), .any(rf_any), .way(rf_way)
    );

    tlb_victim u_victim (
        .match(rf_match), .valid(p_vld), .lru_way(lru_q[rf_idx]), .pick(victim)
    );

    assign fill_go = rf_valid && rf_present && !flush_all;

    // recency: stored bit names the least recently used way
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (lk_hit)  lru_q[lk_idx] <= ~hit_way;
            if (fill_go) lru_q[rf_idx] <= ~victim;
        end
    end

    // lookup outcome
    always_comb begin
        allowed  = lk_write ? w_perm[hit_way][PERM_WR] : w_perm[hit_way][PERM_RD];
        lk_hit   = lk_valid && found && allowed;
        lk_fault = lk_valid && found && !allowed;
        lk_miss  = lk_valid && !found;
        lk_ppn   = lk_hit ? w_ppn[hit_way] : '0;
        lk_dirty = (lk_hit || lk_fault) && w_dirty[hit_way];
        lk_ref   = (lk_hit || lk_fault) && w_ref[hit_way];
    end

    logic unused_ok;
    assign unused_ok = ^{rf_any, rf_way, lk_match};
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VPN_W = 26,
    parameter int PPN_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_all,
    input logic             lk_valid,
    input logic             lk_write,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             lk_dirty,
    input logic             lk_ref,
    input logic             rf_valid,
    input logic             rf_present,
    input logic [VPN_W-1:0] rf_vpn,
    input logic [PPN_W-1:0] rf_ppn
);
    // R11
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    // R3
    fault_noppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_ppn == '0));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (!lk_valid || lk_miss));

    // R2
    refill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && rf_present && !flush_all) |=>
            (!(lk_valid && lk_vpn == $past(rf_vpn)) ||
             ((lk_hit || lk_fault) && (!lk_hit || lk_ppn == $past(rf_ppn)))));

    // R5
    dirty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && !flush_all && !rf_valid) |=>
            (!(lk_valid && lk_vpn == $past(lk_vpn)) ||
             (!lk_miss && lk_dirty && lk_ref)));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_ppn(lk_ppn), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
    .rf_valid(rf_valid), .rf_present(rf_present), .rf_vpn(rf_vpn),
    .rf_ppn(rf_ppn)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
    localparam int VPN_W = 26;
    localparam int PPN_W = 22;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush_all = 1'b0;
    logic             lk_valid = 1'b0, lk_write = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref;
    logic [PPN_W-1:0] lk_ppn;
    logic             rf_valid = 1'b0, rf_present = 1'b0;
    logic [VPN_W-1:0] rf_vpn = '0;
    logic [PPN_W-1:0] rf_ppn = '0;
    logic [1:0]       rf_rights = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_ppn(lk_ppn), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
        .rf_valid(rf_valid), .rf_present(rf_present), .rf_vpn(rf_vpn),
        .rf_ppn(rf_ppn), .rf_rights(rf_rights)
    );

    function automatic logic [VPN_W-1:0] mk(input int tag, input int idx);
        return {tag[17:0], idx[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 1'b0; lk_write = 1'b0; rf_valid = 1'b0; rf_present = 1'b0;
        flush_all = 1'b0;
    endtask

    // single lookup, sampled mid-cycle before the updating edge
    task automatic look(input logic [VPN_W-1:0] v, input bit wr,
                        output logic [5:0] res, output logic [PPN_W-1:0] p);
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_vpn = v;
        #2;
        res = {lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref, 1'b0};
        p = lk_ppn;
        @(posedge clk); #1 idle();
    endtask

    task automatic refill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                          input logic [1:0] perm, input bit present);
        @(negedge clk);
        rf_valid = 1'b1; rf_present = present; rf_vpn = v; rf_ppn = p;
        rf_rights = perm;
        @(posedge clk); #1 idle();
    endtask

    task automatic exp_hit(input logic [VPN_W-1:0] v, input bit wr,
                           input logic [PPN_W-1:0] pe, input bit de, input bit re,
                           input string req);
        logic [5:0] r; logic [PPN_W-1:0] p;
        look(v, wr, r, p);
        chk(r[5:3] == 3'b100, {req, " hit"}, 32'(r[5:3]), 32'h4);
        chk(p == pe, {req, " ppn"}, 32'(p), 32'(pe));
        chk(r[2:1] == {de, re}, {req, " dirty/ref"}, 32'(r[2:1]), 32'({de, re}));
    endtask

    task automatic exp_miss(input logic [VPN_W-1:0] v, input string req);
        logic [5:0] r; logic [PPN_W-1:0] p;
        look(v, 1'b0, r, p);
        chk(r[5:3] == 3'b010 && p == '0, {req, " miss"}, 32'(r[5:3]), 32'h2);
    endtask

    task automatic exp_fault(input logic [VPN_W-1:0] v, input bit wr, input bit de,
                             input string req);
        logic [5:0] r; logic [PPN_W-1:0] p;
        look(v, wr, r, p);
        chk(r[5:3] == 3'b001, {req, " fault"}, 32'(r[5:3]), 32'h1);
        chk(p == '0, {req, " fault ppn"}, 32'(p), 32'h0);
        chk(r[2] == de, {req, " fault dirty"}, 32'(r[2]), 32'(de));
    endtask

    task automatic t_reset();
        #2;
        chk({lk_hit, lk_miss, lk_fault} == 3'b000, "R11 idle outputs",
            32'({lk_hit, lk_miss, lk_fault}), 32'h0);
        exp_miss(mk(5, 3), "R1 empty after reset");
    endtask

    task automatic t_fill_hit();
        refill(mk(5, 3), 22'h12345, 2'b11, 1'b1);
        exp_hit(mk(5, 3), 1'b0, 22'h12345, 1'b0, 1'b0, "R2 R12 first hit");
        exp_hit(mk(5, 3), 1'b0, 22'h12345, 1'b0, 1'b1, "R4 ref set");
        exp_miss(mk(6, 3), "R1 other tag");
        exp_miss(mk(5, 4), "R1 other set");
    endtask

    task automatic t_perm();
        refill(mk(7, 10), 22'h00a0a, 2'b01, 1'b1);
        exp_fault(mk(7, 10), 1'b1, 1'b0, "R3 write on read-only");
        exp_hit(mk(7, 10), 1'b0, 22'h00a0a, 1'b0, 1'b0, "R5 fault left flags");
        refill(mk(8, 11), 22'h00b0b, 2'b10, 1'b1);
        exp_fault(mk(8, 11), 1'b0, 1'b0, "R3 read on write-only");
        exp_hit(mk(8, 11), 1'b1, 22'h00b0b, 1'b0, 1'b0, "R5 first write");
        exp_hit(mk(8, 11), 1'b1, 22'h00b0b, 1'b1, 1'b1, "R5 dirty set");
        exp_fault(mk(8, 11), 1'b0, 1'b1, "R5 dirty seen on fault");
    endtask

    task automatic t_lru();
        refill(mk(1, 20), 22'd100, 2'b11, 1'b1);
        refill(mk(2, 20), 22'd200, 2'b11, 1'b1);
        exp_hit(mk(1, 20), 1'b0, 22'd100, 1'b0, 1'b0, "R6 way a");
        refill(mk(3, 20), 22'd300, 2'b11, 1'b1);
        exp_miss(mk(2, 20), "R7 lru evicted");
        exp_hit(mk(3, 20), 1'b0, 22'd300, 1'b0, 1'b0, "R6 R7 new entry");
        exp_hit(mk(1, 20), 1'b0, 22'd100, 1'b0, 1'b1, "R7 mru kept");
        refill(mk(4, 20), 22'd400, 2'b11, 1'b1);
        exp_miss(mk(3, 20), "R7 second eviction");
        exp_hit(mk(1, 20), 1'b0, 22'd100, 1'b0, 1'b1, "R7 survivor");
        exp_hit(mk(4, 20), 1'b0, 22'd400, 1'b0, 1'b0, "R7 newest");
    endtask

    task automatic t_rewrite();
        refill(mk(9, 30), 22'd1, 2'b11, 1'b1);
        refill(mk(9, 30), 22'd2, 2'b11, 1'b1);
        exp_hit(mk(9, 30), 1'b0, 22'd2, 1'b0, 1'b0, "R8 overwrite");
        refill(mk(10, 30), 22'd3, 2'b11, 1'b1);
        exp_hit(mk(9, 30), 1'b0, 22'd2, 1'b0, 1'b1, "R8 after second page");
        refill(mk(11, 30), 22'd4, 2'b11, 1'b1);
        exp_miss(mk(10, 30), "R8 single copy evict");
        exp_hit(mk(9, 30), 1'b1, 22'd2, 1'b0, 1'b1, "R8 still present");
        exp_hit(mk(9, 30), 1'b0, 22'd2, 1'b1, 1'b1, "R5 dirty after write");
        refill(mk(9, 30), 22'd5, 2'b11, 1'b1);
        exp_hit(mk(9, 30), 1'b0, 22'd5, 1'b0, 1'b0, "R12 flags cleared");
    endtask

    task automatic t_absent();
        refill(mk(12, 40), 22'd7, 2'b11, 1'b0);
        exp_miss(mk(12, 40), "R9 absent refill ignored");
    endtask

    task automatic t_flush();
        logic h; logic [PPN_W-1:0] p;
        @(negedge clk);
        flush_all = 1'b1;
        rf_valid = 1'b1; rf_present = 1'b1; rf_vpn = mk(50, 50); rf_ppn = 22'd9;
        rf_rights = 2'b11;
        lk_valid = 1'b1; lk_write = 1'b0; lk_vpn = mk(1, 20);
        #2;
        h = lk_hit; p = lk_ppn;
        chk(h && p == 22'd100, "R10 lookup in flush cycle", 32'(p), 32'd100);
        @(posedge clk); #1 idle();
        exp_miss(mk(1, 20), "R10 flushed");
        exp_miss(mk(9, 30), "R10 flushed other set");
        exp_miss(mk(50, 50), "R10 refill dropped");
        #2;
        chk({lk_hit, lk_miss, lk_fault} == 3'b000, "R11 idle after flush",
            32'({lk_hit, lk_miss, lk_fault}), 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill_hit();
        t_perm();
        t_lru();
        t_rewrite();
        t_absent();
        t_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule